// File: doc/BRIEF.md
# Strap-Selected Nonvolatile Memory Interface

This block sits between a network controller and its on-board memories. While hardware reset is held it watches a shared strap pin. The level on that pin decides whether the attached nonvolatile memory is a parallel flash device or a serial EEPROM. Once reset is released, the same pin becomes the nonvolatile chip select. Its active level follows the detected memory type.

When an EEPROM was detected, a simple start/address/command/done request runs one serial word transfer. The transfer uses three lines of the shared memory data bus: a command line, a bidirectional data line and a generated serial clock. The block also produces the SRAM chip select for buffer-memory accesses. It produces one read strobe that serves both SRAM and flash reads.

Top module: `nvmem_port`

## Requirements
- R1: A high strap level sampled during reset selects flash. In that mode `nv_cs` is driven low only while `flash_acc` is high and is high otherwise, and `ser_mode` is 0.
- R2: A low strap level selects EEPROM (`ser_mode`=1). `nv_cs` is then high for the whole of a serial transfer and low between transfers.
- R3: `nv_cs_oe` is 0 while `rst` is high. It rises on the first clock edge with `rst` low, and the detected type is held from that edge on whatever `strap_in` does later.
- R4: In flash mode `req_start` has no effect: `sclk` stays low and `req_done` never pulses.
- R5: During a transfer `sclk` has a period of DIV system clocks (24 by default), low for the first DIV/2 and high for the second DIV/2. It is low when idle.
- R6: Each transfer has a header of 2+AW bits on `cmd_out`, one bit per `sclk` period, most significant first. The header is the opcode (read = 2'b10, write = 2'b01) followed by the address. Each bit changes at the start of its period and is stable at the rising `sclk` edge.
- R7: A write then sends DW data bits on `sd_out`, most significant first. `sd_oe` is high only during those data periods of a write.
- R8: A read samples `sd_in` at each rising `sclk` edge of the DW data periods, most significant first. It presents the word on `req_rdata` in the cycle `req_done` is high.
- R9: `req_done` is a single-cycle pulse. It rises (2+AW+DW)*DIV clocks after the clock edge that accepted the request.
- R10: `req_start` raised while a transfer is in progress is ignored. The running transfer completes unchanged and no second transfer follows.
- R11: `sram_cs_n` is low exactly while `buf_acc` is high. `rd_strobe_n` is low while `mem_rd` is high together with either `buf_acc`, or `flash_acc` in flash mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Hardware reset, active high, synchronous |
| strap_in | input | 1 | Level read from the shared strap/chip-select pin |
| nv_cs | output | 1 | Nonvolatile chip select value driven onto the shared pin |
| nv_cs_oe | output | 1 | Output enable of the shared pin |
| ser_mode | output | 1 | 1 when the three data lines act as the serial EEPROM port |
| req_start | input | 1 | Request a serial transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Word to write |
| req_done | output | 1 | Transfer finished pulse |
| req_rdata | output | DW | Word read by the last read transfer |
| sd_in | input | 1 | Serial data from the EEPROM (data line 0) |
| sd_out | output | 1 | Serial data to the EEPROM (data line 0) |
| sd_oe | output | 1 | Drive enable for data line 0 |
| cmd_out | output | 1 | Serial command line (data line 1) |
| sclk | output | 1 | Serial clock (data line 2) |
| buf_acc | input | 1 | Buffer-memory (SRAM) access in progress |
| flash_acc | input | 1 | Flash access in progress |
| mem_rd | input | 1 | Read phase of the current access |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| rd_strobe_n | output | 1 | Shared SRAM/flash read strobe, active low |

## Verification
The serial engine is driven with a table of transfers. The table mixes writes and reads, all-ones and all-zero addresses, and data words with alternating, sparse and full bit patterns. Because of that mix, a swapped opcode, a reversed bit order, a one-period slip or a stuck data line each leaves a different mark. Reads feed a known word on the data input so that the sampling edge and the bit order can be told apart. One transfer is hit by a second request halfway through, to show that it is ignored. Reset is then repeated with the strap high, and the strap is moved after reset, to separate the two chip-select polarities, the strap latch and the read strobe paths.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [1:0] {
      NVM_OP_WRITE = 2'b01,
      NVM_OP_READ  = 2'b10
   } nvm_op_e;
   localparam int NVM_OP_W = 2;
endpackage

// File: rtl/nvm_strap_latch.sv
module nvm_strap_latch (
   input  logic clk,
   input  logic rst,
   input  logic strap_in,
   output logic is_flash,
   output logic valid
);
   always_ff @(posedge clk) begin
      if (rst) begin
         is_flash <= strap_in;
         valid    <= 1'b0;
      end else begin
         valid    <= 1'b1;
      end
   end

   a_r3_type_held: assert property (@(posedge clk) disable iff (rst)
      (valid && $past(valid)) |-> $stable(is_flash));
   a_r3_no_drive_in_reset: assert property (@(posedge clk)
      rst |=> !valid);
endmodule

// File: rtl/nvm_sclk_gen.sv
module nvm_sclk_gen #(
   parameter int DIV = 24
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic sclk,
   output logic rise,
   output logic slot_end
);
   localparam int HALF = DIV / 2;
   localparam int CW   = $clog2(DIV);
   localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

   initial begin
      assert (DIV >= 4 && (DIV % 2) == 0)
         else $error("DIV must be even and at least 4");
   end

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst || !run) cnt <= '0;
            else             cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst || !run)               cnt <= '0;
            else if (cnt == CW'(DIV - 1))  cnt <= '0;
            else                           cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   assign sclk     = run && (cnt >= CW'(HALF));
   assign rise     = run && (cnt == CW'(HALF - 1));
   assign slot_end = run && (cnt == CW'(DIV - 1));

   a_r5_rise_then_high: assert property (@(posedge clk) disable iff (rst)
      (rise && run) |=> sclk);
   a_r5_end_then_low: assert property (@(posedge clk) disable iff (rst)
      slot_end |=> !sclk);
endmodule

// File: rtl/nvm_serial_engine.sv
module nvm_serial_engine #(
   parameter int AW  = 6,
   parameter int DW  = 16,
   parameter int DIV = 24
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          enable,
   input  logic          start,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          sd_in,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rdata,
   output logic          cmd_out,
   output logic          sd_out,
   output logic          sd_oe,
   output logic          sclk
);
   import nvm_pkg::*;

   localparam int HB = NVM_OP_W + AW;
   localparam int N  = HB + DW;
   localparam int SW = $clog2(N);

   initial begin
      assert (AW >= 1 && DW >= 2)
         else $error("AW must be >= 1 and DW >= 2");
   end

   logic          rise, slot_end, wr_q;
   logic [SW-1:0] slot;
   logic [N-1:0]  sh;
   logic [DW-1:0] rd_sh;
   logic [1:0]    opv;
   logic          data_ph;

   nvm_sclk_gen #(.DIV(DIV)) u_div (
      .clk(clk), .rst(rst), .run(busy),
      .sclk(sclk), .rise(rise), .slot_end(slot_end)
   );

   assign opv     = wr ? NVM_OP_WRITE : NVM_OP_READ;
   assign data_ph = (slot >= SW'(HB));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         wr_q  <= 1'b0;
         slot  <= '0;
         sh    <= '0;
         rd_sh <= '0;
         rdata <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start && enable) begin
               busy <= 1'b1;
               wr_q <= wr;
               slot <= '0;
               sh   <= {opv, addr, (wr ? wdata : {DW{1'b0}})};
            end
         end else begin
            if (rise && data_ph && !wr_q)
               rd_sh <= {rd_sh[DW-2:0], sd_in};
            if (slot_end) begin
               if (slot == SW'(N - 1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  if (!wr_q) rdata <= rd_sh;
               end else begin
                  slot <= slot + 1'b1;
                  sh   <= {sh[N-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign cmd_out = busy && !data_ph && sh[N-1];
   assign sd_oe   = busy && data_ph && wr_q;
   assign sd_out  = sd_oe && sh[N-1];

   a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r10_slot_hold: assert property (@(posedge clk) disable iff (rst)
      (busy && !slot_end) |=> (busy && slot == $past(slot)));
   a_r7_oe_write_only: assert property (@(posedge clk) disable iff (rst)
      sd_oe |-> (wr_q && !cmd_out));
   a_r4_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
      (!busy && !enable) |=> !busy);
endmodule

// File: rtl/nvmem_port.sv
module nvmem_port #(
   parameter int AW  = 6,
   parameter int DW  = 16,
   parameter int DIV = 24
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          strap_in,
   output logic          nv_cs,
   output logic          nv_cs_oe,
   output logic          ser_mode,
   input  logic          req_start,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_done,
   output logic [DW-1:0] req_rdata,
   input  logic          sd_in,
   output logic          sd_out,
   output logic          sd_oe,
   output logic          cmd_out,
   output logic          sclk,
   input  logic          buf_acc,
   input  logic          flash_acc,
   input  logic          mem_rd,
   output logic          sram_cs_n,
   output logic          rd_strobe_n
);
   logic is_flash, valid, busy;

   nvm_strap_latch u_strap (
      .clk(clk), .rst(rst), .strap_in(strap_in),
      .is_flash(is_flash), .valid(valid)
   );

   assign ser_mode = valid && !is_flash;

   nvm_serial_engine #(.AW(AW), .DW(DW), .DIV(DIV)) u_ser (
      .clk(clk), .rst(rst), .enable(ser_mode),
      .start(req_start), .wr(req_write), .addr(req_addr), .wdata(req_wdata),
      .sd_in(sd_in), .busy(busy), .done(req_done), .rdata(req_rdata),
      .cmd_out(cmd_out), .sd_out(sd_out), .sd_oe(sd_oe), .sclk(sclk)
   );

   assign nv_cs_oe    = valid;
   assign nv_cs       = valid && (is_flash ? !flash_acc : busy);
   assign sram_cs_n   = !buf_acc;
   assign rd_strobe_n = !(mem_rd && (buf_acc || (valid && is_flash && flash_acc)));

   a_r4_flash_idle: assert property (@(posedge clk) disable iff (rst)
      (valid && is_flash) |-> (!busy && !sclk));
   a_r2_cs_released_after_done: assert property (@(posedge clk) disable iff (rst)
      (req_done && ser_mode) |-> !nv_cs);
   a_r11_sram_select: assert property (@(posedge clk) disable iff (rst)
      !sram_cs_n |-> buf_acc);
endmodule

// File: tb/nvmem_port_test.sv
module nvmem_port_test;
   localparam int AW   = 6;
   localparam int DW   = 16;
   localparam int DIV  = 24;
   localparam int HALF = DIV / 2;
   localparam int HB   = 2 + AW;
   localparam int N    = HB + DW;

   // {write, addr, data}
   localparam logic [22:0] VEC [4] = '{
      {1'b1, 6'h2A, 16'hA55A},
      {1'b0, 6'h15, 16'h3C96},
      {1'b1, 6'h3F, 16'h0001},
      {1'b0, 6'h00, 16'hFFFF}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic strap_in = 1'b0;
   logic req_start = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic sd_in = 1'b0, buf_acc = 1'b0, flash_acc = 1'b0, mem_rd = 1'b0;
   logic nv_cs, nv_cs_oe, ser_mode, req_done, sd_out, sd_oe, cmd_out, sclk;
   logic sram_cs_n, rd_strobe_n;
   logic [DW-1:0] req_rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   nvmem_port #(.AW(AW), .DW(DW), .DIV(DIV)) uut (
      .clk(clk), .rst(rst), .strap_in(strap_in), .nv_cs(nv_cs), .nv_cs_oe(nv_cs_oe),
      .ser_mode(ser_mode), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
      .req_rdata(req_rdata), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
      .cmd_out(cmd_out), .sclk(sclk), .buf_acc(buf_acc), .flash_acc(flash_acc),
      .mem_rd(mem_rd), .sram_cs_n(sram_cs_n), .rd_strobe_n(rd_strobe_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   task automatic run_xfer(input bit wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input bit poke);
      logic [N-1:0] fr;
      int hdr = 0, dat = 0, oe = 0, per = 0, cs = 0;
      int rises = 0, highs = 0, last = -1, cyc = 0;
      bit prev = 1'b0;
      fr = {(wr ? 2'b01 : 2'b10), a, d};
      sd_in = 1'b0;
      @(negedge clk);
      req_write = wr; req_addr = a; req_wdata = d; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      while (!req_done && cyc < 5000) begin
         if (nv_cs !== 1'b1) cs++;
         if (sclk) highs++;
         if (sclk && !prev) begin
            if (last >= 0 && (cyc - last) != DIV) per++;
            last = cyc;
            if (rises < HB) begin
               if (cmd_out !== fr[N-1-rises]) hdr++;
               if (sd_oe) oe++;
            end else begin
               if (sd_oe !== wr) oe++;
               if (wr && sd_out !== fr[N-1-rises]) dat++;
               if (cmd_out) hdr++;
            end
            rises++;
            sd_in = (rises >= HB && rises < N) ? d[DW-1-(rises-HB)] : 1'b0;
         end
         prev = sclk;
         if (poke && cyc == 100) begin
            req_start = 1'b1; req_addr = ~a; req_write = ~wr; req_wdata = ~d;
         end else if (poke && cyc == 101) begin
            req_start = 1'b0;
         end
         cyc++;
         @(negedge clk);
      end
      chk(hdr == 0, poke ? "R10" : "R6", "header bit errors", hdr, 0);
      chk(dat == 0 && oe == 0, "R7", "write data/oe errors", dat + oe, 0);
      chk(per == 0 && rises == N && highs == N * HALF, "R5", "sclk shape (high count)",
          highs, N * HALF);
      chk(cyc == N * DIV, "R9", "cycles to done", cyc, N * DIV);
      chk(cs == 0, "R2", "cs low during transfer", cs, 0);
      if (!wr) chk(req_rdata === d, "R8", "read word", int'(req_rdata), int'(d));
      @(negedge clk);
      chk(req_done === 1'b0 && nv_cs === 1'b0, "R9", "done pulse width / cs release",
          {req_done, nv_cs}, 0);
      if (poke) begin
         int hi = 0;
         for (int i = 0; i < 60; i++) begin
            if (sclk || nv_cs) hi++;
            @(negedge clk);
         end
         chk(hi == 0, "R10", "no follow-on transfer", hi, 0);
      end
   endtask

   initial begin
      // reset with strap low (EEPROM)
      repeat (3) @(negedge clk);
      chk(nv_cs_oe === 1'b0 && sclk === 1'b0, "R3", "pin undriven in reset",
          {nv_cs_oe, sclk}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(nv_cs_oe === 1'b1, "R3", "pin driven after reset", nv_cs_oe, 1);
      chk(ser_mode === 1'b1 && nv_cs === 1'b0, "R2", "eeprom mode idle cs",
          {ser_mode, nv_cs}, 2);
      strap_in = 1'b1;
      repeat (2) @(negedge clk);
      chk(ser_mode === 1'b1, "R3", "strap ignored after reset", ser_mode, 1);
      strap_in = 1'b0;

      for (int v = 0; v < 4; v++)
         run_xfer(VEC[v][22], VEC[v][21:16], VEC[v][15:0], 1'b0);
      run_xfer(1'b1, 6'h0C, 16'h5A0F, 1'b1);

      // buffer memory strobes in EEPROM mode
      buf_acc = 1'b1; mem_rd = 1'b1; #1;
      chk(sram_cs_n === 1'b0 && rd_strobe_n === 1'b0, "R11", "sram read",
          {sram_cs_n, rd_strobe_n}, 0);
      buf_acc = 1'b0; flash_acc = 1'b1; #1;
      chk(sram_cs_n === 1'b1 && rd_strobe_n === 1'b1, "R11", "no flash read in eeprom mode",
          {sram_cs_n, rd_strobe_n}, 3);
      flash_acc = 1'b0; mem_rd = 1'b0;

      // reset again with strap high (flash)
      @(negedge clk);
      rst = 1'b1; strap_in = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      strap_in = 1'b0;
      chk(ser_mode === 1'b0 && nv_cs === 1'b1 && nv_cs_oe === 1'b1, "R1",
          "flash idle cs high", {ser_mode, nv_cs, nv_cs_oe}, 3);
      flash_acc = 1'b1; mem_rd = 1'b1; #1;
      chk(nv_cs === 1'b0 && rd_strobe_n === 1'b0 && sram_cs_n === 1'b1, "R1",
          "flash access cs low, shared strobe", {nv_cs, rd_strobe_n, sram_cs_n}, 1);
      flash_acc = 1'b0; mem_rd = 1'b0;
      @(negedge clk);
      chk(ser_mode === 1'b0, "R3", "type held after strap moved", ser_mode, 0);
      req_start = 1'b1; req_write = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      begin
         int act = 0;
         for (int i = 0; i < 100; i++) begin
            if (sclk || req_done) act++;
            @(negedge clk);
         end
         chk(act == 0, "R4", "no serial activity in flash mode", act, 0);
      end
      summary();
   end
endmodule